// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character into a serial UART frame each time it is asked. A frame opens with a start bit, carries 7, 8 or 9 data bits and an optional parity bit, and closes with one or two stop bits. The bits are timed by an external baud tick, and each bit lasts sixteen ticks. Several run-time options shape the waveform:

- the order of the data bits;
- inversion of the data, which also inverts the parity bit;
- inversion of the whole line;
- a swap of which of the two physical pins transmits and which one receives.

The receive side of this block only maps the pins. It picks the pin that currently acts as the receiver, applies the optional receive inversion, and presents the result as a logical receive line for a receiver elsewhere.

The configuration sits in a register loaded by a write strobe. That register accepts writes only while the unit is disabled and idle, so the line format cannot change under a running frame. A new character is taken on a start strobe while the unit is enabled and not busy.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, busy is 0 and the configuration is the default: 8 data bits, no parity, one stop bit, LSB first, no inversion, no swap. Pin A is driven (pin_a_oe=1) at level 1, and pin B is not driven (pin_b_oe=0).
- R2: A start strobe is accepted when enable=1 and busy=0. The frame it sends is a logical 0 start bit, then the data bits, then the optional parity bit, then logical 1 stop bits. Each bit is held for 16 counted baud ticks.
- R3: With cfg_msb_first=0, data bit 0 follows the start bit. With cfg_msb_first=1, the top bit of the selected length follows the start bit: bit 6, 7 or 8.
- R4: cfg_len selects the data length: 0 gives 7 bits (tx_data[6:0]), 1 gives 8 bits (tx_data[7:0]), and 2 or 3 give 9 bits (tx_data[8:0]).
- R5: With cfg_par_en=1, a parity bit follows the last data bit. The parity is taken over the selected logical data bits before any data inversion. It is their XOR for even parity (cfg_par_odd=0) and the complement of that XOR for odd parity.
- R6: cfg_data_inv=1 inverts every data bit and the parity bit on the line. It leaves the start and stop bits unchanged.
- R7: cfg_tx_inv=1 inverts the whole transmitted waveform, including the idle level, so the line idles at 0.
- R8: cfg_stop2=1 sends two stop bits instead of one, which makes the frame 16 ticks longer.
- R9: With cfg_swap=1, pin B transmits (pin_b_oe=1), pin A is not driven (pin_a_oe=0), and pin A is the receiver. With cfg_swap=0 the roles are reversed.
- R10: rx_line equals the receiving pin's input, XOR cfg_rx_inv.
- R11: cfg_wr loads the configuration inputs only when enable=0 and busy=0. Any other write is ignored. A frame already in flight completes unchanged even if enable drops.
- R12: busy rises in the cycle after an accepted start and falls on the tick that ends the last stop bit. Start strobes made while busy, or while enable=0, are ignored.
- R13: Bit timing advances only in cycles with baud_tick=1, so with a slower tick each bit lasts proportionally more clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Unit enable; starts require 1, config writes require 0 |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_msb_first | input | 1 | Send the most significant data bit first |
| cfg_data_inv | input | 1 | Invert data and parity bits |
| cfg_tx_inv | input | 1 | Invert the transmitted line |
| cfg_rx_inv | input | 1 | Invert the received line |
| cfg_swap | input | 1 | Swap transmit and receive pins |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_par_en | input | 1 | Add a parity bit |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_len | input | 2 | Data length select |
| tx_data | input | 9 | Character to send |
| tx_start | input | 1 | Start strobe |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| pin_a_in | input | 1 | Level sampled on pin A |
| pin_a_out | output | 1 | Level driven on pin A |
| pin_a_oe | output | 1 | Output enable of pin A |
| pin_b_in | input | 1 | Level sampled on pin B |
| pin_b_out | output | 1 | Level driven on pin B |
| pin_b_oe | output | 1 | Output enable of pin B |
| busy | output | 1 | Frame in progress |
| rx_line | output | 1 | Logical receive line after mapping and inversion |

## Verification
Several properties are checked on every cycle:

- the configuration holds still while the unit is enabled or busy;
- exactly one pin is driven;
- the idle line sits at the level the line inversion selects;
- a frame always opens with a low start bit;
- the line never moves in a cycle without a tick;
- busy only ends on a tick.

Whether the bits come out in the right order and polarity, with the right parity and length, can only be shown by the bench. It sweeps every combination of length, order, data inversion, parity mode and stop count, and also runs all 256 8-bit characters. It then covers the ignored writes and starts, the pin swap and receive inversion, and a slower tick rate.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef struct packed {
    logic       msb_first;
    logic       data_inv;
    logic       tx_inv;
    logic       rx_inv;
    logic       swap;
    logic       stop2;
    logic       par_en;
    logic       par_odd;
    logic [1:0] len_sel;
  } uft_cfg_t;

  localparam uft_cfg_t UFT_CFG_RST = '{
    msb_first: 1'b0,
    data_inv:  1'b0,
    tx_inv:    1'b0,
    rx_inv:    1'b0,
    swap:      1'b0,
    stop2:     1'b0,
    par_en:    1'b0,
    par_odd:   1'b0,
    len_sel:   2'd1
  };

endpackage

// File: rtl/uft_rst_sync.sv
module uft_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/uft_cfg_reg.sv
module uft_cfg_reg
  import uft_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     busy,
  input  logic     wr,
  input  uft_cfg_t cfg_d,
  output uft_cfg_t cfg_q
);
  logic     wr_ok;
  uft_cfg_t cfg_nx;

  always_comb begin
    wr_ok  = wr & ~enable & ~busy;
    cfg_nx = cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= UFT_CFG_RST;
    else if (wr_ok) cfg_q <= cfg_nx;
  end

  // R11: frozen while the unit is enabled or a frame is running
  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable || busy) |=> $stable(cfg_q));
  // R11: no strobe, no change
  assert_cfg_needs_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cfg_q));
endmodule

// File: rtl/uft_frame_build.sv
module uft_frame_build #(
  parameter int DATA_W  = 9,
  parameter int FRAME_W = DATA_W + 4,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [1:0]         len_sel,
  input  logic               msb_first,
  input  logic               data_inv,
  input  logic               par_en,
  input  logic               par_odd,
  input  logic               stop2,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   total
);
  localparam int NB_W = $clog2(DATA_W + 1);

  logic [NB_W-1:0]    nbits;
  logic [DATA_W-1:0]  mask;
  logic [DATA_W-1:0]  rev;
  logic [DATA_W-1:0]  ord;
  logic [DATA_W-1:0]  pay;
  logic               par_bit;
  logic [FRAME_W-1:0] dat_f;
  logic [FRAME_W-1:0] dat_m;
  logic [FRAME_W-1:0] par_m;

  // full-width bit reversal; shifted down to the selected length below
  for (genvar g = 0; g < DATA_W; g++) begin : g_rev
    assign rev[g] = data[DATA_W-1-g];
  end

  always_comb begin
    case (len_sel)
      2'd0:    nbits = NB_W'(DATA_W - 2);
      2'd1:    nbits = NB_W'(DATA_W - 1);
      default: nbits = NB_W'(DATA_W);
    endcase
    mask    = ~({DATA_W{1'b1}} << nbits);
    ord     = msb_first ? (rev >> (NB_W'(DATA_W) - nbits)) : data;
    pay     = (ord ^ {DATA_W{data_inv}}) & mask;
    par_bit = (^(data & mask)) ^ par_odd ^ data_inv;
    dat_f   = FRAME_W'(pay) << 1;
    dat_m   = FRAME_W'(mask) << 1;
    par_m   = par_en ? ((FRAME_W'(1) << nbits) << 1) : '0;
    // start bit at 0, payload, parity, then ones for stop bits
    frame   = dat_f | (par_bit ? par_m : '0) | ~(dat_m | par_m | FRAME_W'(1));
    total   = LEN_W'(nbits) + LEN_W'(2) + LEN_W'(par_en) + LEN_W'(stop2);
  end
endmodule

// File: rtl/uft_serializer.sv
module uft_serializer #(
  parameter int FRAME_W = 13,
  parameter int LEN_W   = $clog2(FRAME_W + 1),
  parameter int OSR     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [LEN_W-1:0]   total_in,
  output logic               ser,
  output logic               busy
);
  localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

  logic [FRAME_W-1:0] sh_q, sh_nx;
  logic [LEN_W-1:0]   left_q, left_nx;
  logic [CNT_W-1:0]   cnt_q, cnt_nx;
  logic               busy_q, busy_nx;
  logic               accept;
  logic               bit_end;

  always_comb begin
    accept  = load & ~busy_q;
    bit_end = busy_q & baud_tick & (cnt_q == CNT_LAST);
    sh_nx   = sh_q;
    left_nx = left_q;
    cnt_nx  = cnt_q;
    busy_nx = busy_q;
    if (accept) begin
      sh_nx   = frame_in;
      left_nx = total_in;
      cnt_nx  = '0;
      busy_nx = 1'b1;
    end else if (bit_end) begin
      sh_nx   = {1'b1, sh_q[FRAME_W-1:1]};
      left_nx = left_q - LEN_W'(1);
      cnt_nx  = '0;
      if (left_q == LEN_W'(1)) busy_nx = 1'b0;
    end else if (busy_q && baud_tick) begin
      cnt_nx = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_nx;
      left_q <= left_nx;
      cnt_q  <= cnt_nx;
      busy_q <= busy_nx;
    end
  end

  assign busy = busy_q;
  assign ser  = busy_q ? sh_q[0] : 1'b1;

  // R2: every frame opens with a logical low start bit
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (ser == 1'b0));
  // R13: without a tick the line holds
  assert_hold_no_tick_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> $stable(ser));
  // R12: busy ends only on a counted tick
  assert_end_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(baud_tick));
endmodule

// File: rtl/uft_pinmap.sv
module uft_pinmap (
  input  logic ser,
  input  logic tx_inv,
  input  logic rx_inv,
  input  logic swap,
  input  logic pin_a_in,
  input  logic pin_b_in,
  output logic pin_a_out,
  output logic pin_a_oe,
  output logic pin_b_out,
  output logic pin_b_oe,
  output logic rx_line
);
  logic tx_lvl;

  always_comb begin
    tx_lvl    = ser ^ tx_inv;
    pin_a_out = tx_lvl;
    pin_b_out = tx_lvl;
    pin_a_oe  = ~swap;
    pin_b_oe  = swap;
    rx_line   = (swap ? pin_a_in : pin_b_in) ^ rx_inv;
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_wr,
  input  logic              cfg_msb_first,
  input  logic              cfg_data_inv,
  input  logic              cfg_tx_inv,
  input  logic              cfg_rx_inv,
  input  logic              cfg_swap,
  input  logic              cfg_stop2,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [1:0]        cfg_len,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_start,
  input  logic              baud_tick,
  input  logic              pin_a_in,
  output logic              pin_a_out,
  output logic              pin_a_oe,
  input  logic              pin_b_in,
  output logic              pin_b_out,
  output logic              pin_b_oe,
  output logic              busy,
  output logic              rx_line
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic               rst_sn;
  uft_cfg_t           cfg_d, cfg_q;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   total;
  logic               ser;
  logic               load;

  uft_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sn));

  always_comb begin
    cfg_d = '{msb_first: cfg_msb_first, data_inv: cfg_data_inv, tx_inv: cfg_tx_inv,
              rx_inv: cfg_rx_inv, swap: cfg_swap, stop2: cfg_stop2,
              par_en: cfg_par_en, par_odd: cfg_par_odd, len_sel: cfg_len};
    load  = tx_start & enable;
  end

  uft_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_sn), .enable(enable), .busy(busy),
    .wr(cfg_wr), .cfg_d(cfg_d), .cfg_q(cfg_q)
  );

  uft_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_build (
    .data(tx_data), .len_sel(cfg_q.len_sel), .msb_first(cfg_q.msb_first),
    .data_inv(cfg_q.data_inv), .par_en(cfg_q.par_en), .par_odd(cfg_q.par_odd),
    .stop2(cfg_q.stop2), .frame(frame), .total(total)
  );

  uft_serializer #(.FRAME_W(FRAME_W), .LEN_W(LEN_W), .OSR(OSR)) u_ser (
    .clk(clk), .rst_n(rst_sn), .baud_tick(baud_tick), .load(load),
    .frame_in(frame), .total_in(total), .ser(ser), .busy(busy)
  );

  uft_pinmap u_pins (
    .ser(ser), .tx_inv(cfg_q.tx_inv), .rx_inv(cfg_q.rx_inv), .swap(cfg_q.swap),
    .pin_a_in(pin_a_in), .pin_b_in(pin_b_in),
    .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
    .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe), .rx_line(rx_line)
  );

  // R9: exactly one pin is driven
  assert_one_driver_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot({pin_a_oe, pin_b_oe}));
  // R7: idle level follows line inversion on the driving pin
  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    !busy |-> ((pin_a_oe ? pin_a_out : pin_b_out) == ~cfg_q.tx_inv));
  // R12: no frame begins while disabled
  assert_no_start_disabled_R12: assert property (@(posedge clk) disable iff (!rst_sn)
    (!enable && !busy) |=> !busy);
endmodule

// File: tb/uart_frame_tx_test.sv
`timescale 1ns/1ps
module uart_frame_tx_test;
  logic clk = 1'b0;
  logic rst_n;
  logic enable, cfg_wr, cfg_msb_first, cfg_data_inv, cfg_tx_inv, cfg_rx_inv;
  logic cfg_swap, cfg_stop2, cfg_par_en, cfg_par_odd;
  logic [1:0] cfg_len;
  logic [8:0] tx_data;
  logic tx_start, baud_tick, pin_a_in, pin_b_in;
  logic pin_a_out, pin_a_oe, pin_b_out, pin_b_oe, busy, rx_line;

  int tests = 0;
  int fails = 0;
  int tdiv = 1;
  int tph = 0;
  int tcount;
  logic counting = 1'b0;
  logic cur_swap = 1'b0;
  logic cur_txinv = 1'b0;

  always #4 clk = ~clk;

  uart_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
    .cfg_msb_first(cfg_msb_first), .cfg_data_inv(cfg_data_inv),
    .cfg_tx_inv(cfg_tx_inv), .cfg_rx_inv(cfg_rx_inv), .cfg_swap(cfg_swap),
    .cfg_stop2(cfg_stop2), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_len(cfg_len), .tx_data(tx_data), .tx_start(tx_start),
    .baud_tick(baud_tick), .pin_a_in(pin_a_in), .pin_a_out(pin_a_out),
    .pin_a_oe(pin_a_oe), .pin_b_in(pin_b_in), .pin_b_out(pin_b_out),
    .pin_b_oe(pin_b_oe), .busy(busy), .rx_line(rx_line)
  );

  always @(negedge clk) begin
    if (tdiv <= 1) begin
      baud_tick <= 1'b1;
    end else begin
      baud_tick <= (tph == 0);
      tph <= (tph >= tdiv - 1) ? 0 : tph + 1;
    end
  end

  always @(posedge clk) begin
    if (!counting)      tcount <= 0;
    else if (baud_tick) tcount <= tcount + 1;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic tx_obs();
    return cur_swap ? pin_b_out : pin_a_out;
  endfunction

  // expected logical frame, arithmetically from the requirements
  function automatic int exp_frame(input logic [8:0] d, input int len, input int msb,
                                   input int dinv, input int par, input int stop2,
                                   output logic [15:0] bits);
    int n;
    int pos;
    logic p;
    n = (len == 0) ? 7 : (len == 1) ? 8 : 9;
    bits = '1;
    bits[0] = 1'b0;
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      int src;
      int idx;
      src = (msb != 0) ? (n - 1 - i) : i;
      idx = i + 1;
      bits[idx[3:0]] = d[src[3:0]] ^ dinv[0];
      p = p ^ d[i];
    end
    pos = n + 1;
    if (par != 0) begin
      bits[pos[3:0]] = p ^ (par == 2) ^ dinv[0];
      pos++;
    end
    return pos + 1 + stop2;
  endfunction

  task automatic write_cfg(input int len, input int msb, input int dinv, input int txinv,
                           input int rxinv, input int swap, input int stop2, input int par);
    @(negedge clk);
    enable = 1'b0;
    cfg_len = len[1:0];
    cfg_msb_first = msb[0];
    cfg_data_inv = dinv[0];
    cfg_tx_inv = txinv[0];
    cfg_rx_inv = rxinv[0];
    cfg_swap = swap[0];
    cfg_stop2 = stop2[0];
    cfg_par_en = (par != 0);
    cfg_par_odd = (par == 2);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    enable = 1'b1;
    cur_swap = swap[0];
    cur_txinv = txinv[0];
  endtask

  task automatic run_frame(input logic [8:0] d, input int len, input int msb, input int dinv,
                           input int par, input int stop2, input int poke);
    logic [15:0] bits;
    int total;
    int bad;
    int badact;
    int badexp;
    total = exp_frame(d, len, msb, dinv, par, stop2, bits);
    bad = -1;
    badact = 0;
    badexp = 0;
    tx_data = d;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    counting = 1'b1;
    check(busy == 1'b1, "R12 busy after start", int'(busy), 1);
    for (int i = 0; i < total; i++) begin
      logic e;
      while (tcount < 16 * i + 8) @(negedge clk);
      e = bits[i] ^ cur_txinv;
      if (tx_obs() !== e && bad < 0) begin
        bad = i;
        badact = int'(tx_obs());
        badexp = int'(e);
      end
      if (poke != 0 && i == 2) begin
        tx_data = ~d;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        tx_data = d;
      end
    end
    // R2 R3 R4 R5 R6 R7 R8: bitwise frame contents
    check(bad < 0, $sformatf("R2/R3/R4/R5/R6 frame bit %0d d=%0h", bad, d), badact, badexp);
    while (tcount < 16 * total - 1) @(negedge clk);
    check(busy == 1'b1, "R8 busy before last tick", int'(busy), 1);
    while (tcount < 16 * total) @(negedge clk);
    check(busy == 1'b0 && tx_obs() == ~cur_txinv, "R12 busy ends after last stop",
          int'({busy, tx_obs()}), int'({1'b0, ~cur_txinv}));
    counting = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8ns * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int fr;
    rst_n = 1'b0;
    enable = 1'b0;
    cfg_wr = 1'b0;
    cfg_msb_first = 1'b0; cfg_data_inv = 1'b0; cfg_tx_inv = 1'b0; cfg_rx_inv = 1'b0;
    cfg_swap = 1'b0; cfg_stop2 = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    cfg_len = 2'd0;
    tx_data = '0;
    tx_start = 1'b0;
    pin_a_in = 1'b1;
    pin_b_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(pin_a_oe == 1'b1 && pin_b_oe == 1'b0 && pin_a_out == 1'b1, "R1 pins after reset",
          int'({pin_a_oe, pin_b_oe, pin_a_out}), 3'b101);
    // R1: default format is 8N1 LSB first
    enable = 1'b1;
    @(negedge clk);
    run_frame(9'h0A5, 1, 0, 0, 0, 0, 0);

    // R12: start while disabled is ignored
    enable = 1'b0;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && pin_a_out == 1'b1, "R12 start ignored when disabled",
          int'({busy, pin_a_out}), 2'b01);

    // R11: write while enabled is ignored
    enable = 1'b1;
    cfg_swap = 1'b1;
    cfg_tx_inv = 1'b1;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
    check(pin_a_oe == 1'b1 && pin_b_oe == 1'b0 && pin_a_out == 1'b1, "R11 write while enabled",
          int'({pin_a_oe, pin_b_oe, pin_a_out}), 3'b101);

    // R11: write while busy (enable dropped mid-frame) is ignored; frame completes
    cfg_swap = 1'b0;
    cfg_tx_inv = 1'b0;
    tx_data = 9'h000;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    repeat (20) @(negedge clk);
    enable = 1'b0;
    cfg_tx_inv = 1'b1;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    for (int k = 0; k < 400 && busy; k++) @(negedge clk);
    check(busy == 1'b0 && pin_a_out == 1'b1, "R11 write while busy ignored",
          int'({busy, pin_a_out}), 2'b01);

    // R12: start while busy is ignored (poke during frame)
    write_cfg(1, 0, 0, 0, 0, 0, 0, 0);
    run_frame(9'h000, 1, 0, 0, 0, 0, 1);

    // R2 R3 R4 R5 R6 R7 R8 R9: sweep of format options
    fr = 0;
    for (int len = 0; len < 3; len++)
      for (int msb = 0; msb < 2; msb++)
        for (int dinv = 0; dinv < 2; dinv++)
          for (int par = 0; par < 3; par++)
            for (int st = 0; st < 2; st++) begin
              logic [8:0] d;
              d = 9'((len * 37 + msb * 91 + dinv * 53 + par * 19 + st * 7 + fr * 29 + 90) & 511);
              write_cfg(len, msb, dinv, fr % 2, 0, (fr / 3) % 2, st, par);
              run_frame(d, len, msb, dinv, par, st, 0);
              fr++;
            end

    // R4: length select 3 behaves as 9 bits
    write_cfg(3, 1, 0, 0, 0, 0, 0, 1);
    run_frame(9'h1C3, 3, 1, 0, 1, 0, 0);

    // R2 R5: every 8-bit character with even parity
    write_cfg(1, 0, 0, 0, 0, 0, 0, 1);
    for (int v = 0; v < 256; v++) run_frame(9'(v), 1, 0, 0, 1, 0, 0);

    // R13: slower tick stretches each bit
    tdiv = 3;
    repeat (4) @(negedge clk);
    write_cfg(1, 1, 1, 0, 0, 0, 1, 2);
    run_frame(9'h03C, 1, 1, 1, 2, 1, 0);
    tdiv = 1;
    repeat (4) @(negedge clk);

    // R9 R10: pin mapping and receive inversion
    for (int sw = 0; sw < 2; sw++)
      for (int ri = 0; ri < 2; ri++)
        for (int v = 0; v < 2; v++) begin
          write_cfg(1, 0, 0, 0, ri, sw, 0, 0);
          if (sw != 0) begin pin_a_in = v[0]; pin_b_in = ~v[0]; end
          else         begin pin_b_in = v[0]; pin_a_in = ~v[0]; end
          @(negedge clk);
          check(rx_line == (v[0] ^ ri[0]), "R10 rx line mapping", int'(rx_line),
                int'(v[0] ^ ri[0]));
          check(pin_a_oe == ~sw[0] && pin_b_oe == sw[0], "R9 pin direction",
                int'({pin_a_oe, pin_b_oe}), int'({~sw[0], sw[0]}));
        end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule